// File: doc/BRIEF.md
# Dual-Drive ATA PIO Cycle Timer

This block times programmed-I/O read and write cycles on one ATA channel that carries two drives. Every cycle passes through three phases counted in bus clocks: address setup, an active phase with the read or write strobe asserted, and recovery. The setup length is common to both drives. The pulse and recovery lengths come from one of two timing banks, and a mapping register chooses which bank each drive uses. Each bank keeps its own timing byte for reads and its own timing byte for writes.

Software programs the block through a small indexed register port. A request names the drive and the direction. The block accepts it only while idle and takes its timing values at that moment. The block then runs the three phases and marks the final recovery clock with a one-clock done pulse. For reads it also flags the clock on which the host should capture the data. The block shows the DRDY count and the read-prefetch enable on two configuration outputs and does not use them itself.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset the block is idle with all outputs low, `prefetch_en` = 0 and `drdy_clks` = 2. Every timing register holds 0, so a cycle has 1 setup clock, 1 active clock and 2 recovery clocks.
- R2: A timing byte gives an active length of bits [7:4] + 1 (1 to 16 clocks) and a recovery length of bits [3:0] + 2 (2 to 17 clocks).
- R3: The setup length is bits [5:4] + 1 (1 to 4 clocks) of the shared setting register at index 6. The same length applies to both drives and to both directions.
- R4: In the shared setting register, `drdy_clks` equals bits [2:1] + 2 and `prefetch_en` equals bit 6. Bits 7, 3 and 0 are not stored.
- R5: A write to index 6 whose bits [7:1] are all zero does not change the shared settings. Bit 0 of that value picks the bank (0 = A, 1 = B) that later writes to index 0 (read timing) and index 1 (write timing) reach. Any other value written to index 6 updates the shared settings and leaves the bank pointer as it was.
- R6: At index 3, bit 1 selects the bank for drive 0 and bit 2 selects the bank for drive 1 (0 = A, 1 = B). Writing 0x85 therefore gives drive 0 bank A and drive 1 bank B. Writes to indices other than 0, 1, 3 and 6 have no effect.
- R7: A read cycle uses the read timing byte of the drive's bank and pulses `dior`. A write cycle uses the write timing byte and pulses `diow`.
- R8: A cycle runs setup (`addr_setup` high), then active (strobe high), then recovery. No two of these outputs are high together. `done` is high for exactly the last recovery clock, and the block is idle on the following clock.
- R9: On reads, `rd_sample` is high for exactly one clock, the last active clock. It never goes high on writes.
- R10: A request made while a cycle is in progress is dropped. Register writes made during a cycle do not change the timing of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| req_valid | input | 1 | Cycle request, taken only when idle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_drive | input | 1 | Drive select (0 or 1) |
| busy | output | 1 | A cycle is in progress |
| addr_setup | output | 1 | Address setup phase |
| dior | output | 1 | Read strobe, active high |
| diow | output | 1 | Write strobe, active high |
| rd_sample | output | 1 | Capture read data on this clock |
| done | output | 1 | Last recovery clock |
| prefetch_en | output | 1 | Read-prefetch enable setting |
| drdy_clks | output | 3 | DRDY count in clocks |

## Verification
The assertions check the phase rules on every clock. At most one of setup and the two strobes is high at a time. A strobe always follows setup. Done is followed by idle. The read sample falls on a strobe clock that is the last of its active phase. A new setup phase starts only from idle. The phase lengths depend on the bank encoding, the bank pointer, the drive-to-bank map and the values captured when the request was accepted. Only the bench shows these lengths: it counts each phase against lengths it works out from its own copy of the registers. The same holds for dropped requests and register writes made during a cycle.

// File: rtl/ata_pio_timer.sv
module ata_pio_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_idx,
  input  logic [7:0] reg_wdata,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       req_drive,
  output logic       busy,
  output logic       addr_setup,
  output logic       dior,
  output logic       diow,
  output logic       rd_sample,
  output logic       done,
  output logic       prefetch_en,
  output logic [2:0] drdy_clks
);
  typedef enum logic [1:0] {IDLE, SETUP, ACTIVE, RECOV} st_t;

  st_t        st;
  logic [7:0] tim_q [2][2];
  logic       bank_ptr;
  logic [1:0] drv_bank;
  logic [7:0] misc_q;
  logic [4:0] cnt;
  logic [3:0] pulse_q;
  logic [4:0] rec_q;
  logic       wr_q;
  logic [7:0] sel_byte;
  logic       last;

  assign sel_byte    = tim_q[drv_bank[req_drive]][req_write];
  assign last        = (cnt == 5'd0);
  assign busy        = (st != IDLE);
  assign addr_setup  = (st == SETUP);
  assign dior        = (st == ACTIVE) && !wr_q;
  assign diow        = (st == ACTIVE) && wr_q;
  assign rd_sample   = dior && last;
  assign done        = (st == RECOV) && last;
  assign prefetch_en = misc_q[6];
  assign drdy_clks   = {1'b0, misc_q[2:1]} + 3'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int d = 0; d < 2; d++)
          tim_q[b][d] <= 8'h00;
      bank_ptr <= 1'b0;
      drv_bank <= 2'b00;
      misc_q   <= 8'h00;
    end else if (reg_wr) begin
      case (reg_idx)
        3'd0: tim_q[bank_ptr][0] <= reg_wdata;
        3'd1: tim_q[bank_ptr][1] <= reg_wdata;
        3'd3: drv_bank <= reg_wdata[2:1];
        3'd6: begin
          if (reg_wdata[7:1] == 7'd0) bank_ptr <= reg_wdata[0];
          else                        misc_q   <= reg_wdata & 8'h76;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= 5'd0;
      pulse_q <= 4'd0;
      rec_q   <= 5'd0;
      wr_q    <= 1'b0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          st      <= SETUP;
          cnt     <= {3'd0, misc_q[5:4]};
          pulse_q <= sel_byte[7:4];
          rec_q   <= {1'b0, sel_byte[3:0]} + 5'd1;
          wr_q    <= req_write;
        end
        SETUP: if (last) begin
          st  <= ACTIVE;
          cnt <= {1'b0, pulse_q};
        end else cnt <= cnt - 5'd1;
        ACTIVE: if (last) begin
          st  <= RECOV;
          cnt <= rec_q;
        end else cnt <= cnt - 5'd1;
        RECOV: if (last) st <= IDLE;
          else cnt <= cnt - 5'd1;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_pio_timer_chk.sv
module ata_pio_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic addr_setup,
  input logic dior,
  input logic diow,
  input logic rd_sample,
  input logic done
);
  assert_one_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_setup, dior, diow}));
  assert_setup_to_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_setup) |-> (dior || diow));
  assert_done_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_sample_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sample |-> dior);
  assert_sample_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sample |=> !dior);
  assert_start_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_setup) |-> $past(!busy));
endmodule

bind ata_pio_timer ata_pio_timer_chk u_chk (.*);

// File: tb/sim_ata_pio_timer.sv
`timescale 1ns/1ps
module sim_ata_pio_timer;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, req_valid = 0, req_write = 0, req_drive = 0;
  logic [2:0] reg_idx = 0;
  logic [7:0] reg_wdata = 0;
  logic busy, addr_setup, dior, diow, rd_sample, done, prefetch_en;
  logic [2:0] drdy_clks;
  int checks = 0, errors = 0;

  logic [7:0] m_tim [2][2];
  logic       m_ptr;
  logic [1:0] m_map;
  logic [7:0] m_misc;

  always #2 clk = ~clk;

  ata_pio_timer u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] idx, input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1; reg_idx = idx; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0;
    case (idx)
      3'd0: m_tim[m_ptr][0] = v;
      3'd1: m_tim[m_ptr][1] = v;
      3'd3: m_map = v[2:1];
      3'd6: if (v[7:1] == 0) m_ptr = v[0]; else m_misc = v & 8'h76;
      default: ;
    endcase
  endtask

  function automatic int e_setup(); return m_misc[5:4] + 1; endfunction
  function automatic int e_pulse(input bit d, input bit w); return m_tim[m_map[d]][w][7:4] + 1; endfunction
  function automatic int e_rec(input bit d, input bit w); return m_tim[m_map[d]][w][3:0] + 2; endfunction

  task automatic run_cycle(input bit d, input bit w, input bit disturb);
    int es, ep, er, ns, na, nr, nd, samp_at, nsamp;
    bit wrong;
    es = e_setup(); ep = e_pulse(d, w); er = e_rec(d, w);
    ns = 0; na = 0; nr = 0; nd = 0; samp_at = -1; nsamp = 0; wrong = 0;
    @(negedge clk);
    req_valid = 1; req_write = w; req_drive = d;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 80; i++) begin
      if (addr_setup) ns++;
      if (dior || diow) begin
        na++;
        if ((w && dior) || (!w && diow)) wrong = 1;
      end
      if (rd_sample) begin nsamp++; samp_at = na; end
      if (busy && !addr_setup && !dior && !diow) nr++;
      if (done) begin nd++; break; end
      if (disturb && i == 0) begin
        req_valid = 1; req_drive = !d; req_write = !w;
        reg_wr = 1; reg_idx = {2'b00, w}; reg_wdata = 8'hFF;
        m_tim[m_ptr][w] = 8'hFF;
        @(negedge clk);
        req_valid = 0; reg_wr = 0;
      end else @(negedge clk);
    end
    chk(ns == es, "R3 setup clocks", ns, es);
    chk(na == ep, "R2 active clocks", na, ep);
    chk(nr == er, "R2 recovery clocks", nr, er);
    chk(nd == 1 && !wrong, "R7 done seen and strobe line", nd + 10 * wrong, 1);
    if (w) chk(nsamp == 0, "R9 no sample on write", nsamp, 0);
    else   chk(nsamp == 1 && samp_at == ep, "R9 sample on last active clock", samp_at, ep);
    @(negedge clk);
    chk(!busy && !addr_setup && !done, "R8 idle after done", busy, 0);
    if (disturb) begin
      @(negedge clk);
      chk(!busy, "R10 request during cycle dropped", busy, 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5A17);
    for (int b = 0; b < 2; b++) for (int d = 0; d < 2; d++) m_tim[b][d] = 0;
    m_ptr = 0; m_map = 0; m_misc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !addr_setup && !dior && !diow && !done && !rd_sample, "R1 idle outputs", busy, 0);
    chk(!prefetch_en && drdy_clks == 3'd2, "R1 config defaults", drdy_clks, 2);
    run_cycle(0, 0, 0);
    run_cycle(1, 1, 0);

    // R5 bank A read/write bytes, then bank B
    wreg(3'd6, 8'h00); wreg(3'd0, 8'h31); wreg(3'd1, 8'h52);
    wreg(3'd6, 8'h01); wreg(3'd0, 8'h74); wreg(3'd1, 8'h23);
    chk(drdy_clks == 3'd2 && !prefetch_en, "R5 pointer write leaves settings", drdy_clks, 2);
    wreg(3'd3, 8'h85);  // R6
    run_cycle(0, 0, 0); run_cycle(0, 1, 0);
    run_cycle(1, 0, 0); run_cycle(1, 1, 0);
    wreg(3'd5, 8'h11); wreg(3'd2, 8'hFF);  // R6 unused indices
    run_cycle(1, 0, 0);

    // R4 shared settings
    wreg(3'd6, 8'h7E);
    chk(prefetch_en == 1, "R4 prefetch enable", prefetch_en, 1);
    chk(drdy_clks == 3'd5, "R4 drdy count", drdy_clks, 5);
    wreg(3'd6, 8'h96);
    chk(prefetch_en == 0 && drdy_clks == 3'd5, "R4 bit7 not stored", drdy_clks, 5);
    run_cycle(0, 1, 0);

    // R2/R3 maximum lengths
    wreg(3'd6, 8'hB0); wreg(3'd6, 8'h00);
    wreg(3'd0, 8'hFF); wreg(3'd1, 8'hFF);
    run_cycle(0, 0, 0); run_cycle(0, 1, 0);

    // R10 disturbance during a cycle
    wreg(3'd0, 8'h12);
    run_cycle(0, 0, 1);
    wreg(3'd6, 8'h01); wreg(3'd1, 8'h43);
    run_cycle(1, 1, 1);

    // constrained random
    for (int it = 0; it < 60; it++) begin
      int op;
      op = $urandom_range(0, 3);
      if (op == 0) wreg(3'd6, 8'($urandom_range(0, 1)));
      if (op == 1) wreg(3'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
      if (op == 2) wreg(3'd3, 8'($urandom_range(0, 255)));
      if (op == 3) begin
        logic [7:0] v;
        v = 8'($urandom_range(2, 255));
        wreg(3'd6, v);
        chk(prefetch_en == m_misc[6] && drdy_clks == 3'(m_misc[2:1] + 2), "R4 random settings", drdy_clks, m_misc[2:1] + 2);
      end
      run_cycle(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), it % 7 == 3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule